// File: doc/BRIEF.md
# Manchester Receiver with Data-Full and Overrun Flags

This block takes a Manchester-coded serial line, recovers one data bit per bit period from the direction of the mid-bit transition, and assembles the bits into a byte. A byte is only accepted after a closing symbol has been checked. That symbol is a full bit period with no mid-bit transition, so it breaks the Manchester coding on purpose. An accepted byte goes to a read-only data output, and a data-full flag is set. If a byte is accepted while the previous one is still waiting, the overrun flag is set, the old byte is kept and the new one is dropped.

A frame has three parts. First comes a sync bit, which must decode as 1: low in its first half and high in its second. Then come eight data bits, most significant first. Last comes the closing symbol, which may sit at either level. The line idles high, and a falling edge from idle starts a frame. The receiver samples the line on an oversampling strobe that runs at a fixed multiple of the bit rate. It samples each half of the bit, and mid-bit edges realign its phase counter.

Software clears the data-full flag in two steps: a status read while the flag is set, then a data read. Dropping the decoder enable resets the receiver and clears both flags. The interrupt request is the OR of the flags, gated by an interrupt enable.

Top module: `manch_rx_flags`

## Requirements
- R1: After reset, full_flag, ovr_flag and irq are 0 and rx_data is 0x00.
- R2: A frame gives rx_data the eight data bits in order, most significant bit first, and sets full_flag. The frame is: a sync bit of value 1, eight data bits, then a closing bit period with no mid-bit transition. A bit is 1 when its mid-bit transition goes low to high, and 0 when it goes high to low.
- R3: If the closing bit period contains a mid-bit transition, the byte is discarded: no flag changes and rx_data keeps its value.
- R4: If a data bit has no mid-bit transition, the frame is aborted: no flag changes and rx_data keeps its value.
- R5: irq is 1 one cycle after irq_en is 1 and at least one of full_flag or ovr_flag is 1. Otherwise irq is 0.
- R6: full_flag clears only when a data_rd pulse follows a stat_rd pulse that was sampled while full_flag was 1. A data_rd with no such stat_rd before it leaves full_flag set.
- R7: If a valid byte completes while full_flag is 1, ovr_flag is set and rx_data keeps the older byte.
- R8: While dec_en is 0, full_flag, ovr_flag and rx_data are held at 0 and frames on the line are ignored.
- R9: If the data_rd that completes a clear falls in the same cycle as a new valid byte, rx_data takes the new byte, full_flag stays 1 and ovr_flag stays 0.
- R10: A closing period held low is accepted the same way as one held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling strobe, OVS strobes per bit period |
| line_in | input | 1 | Manchester-coded serial line, idles high |
| dec_en | input | 1 | Decoder enable; 0 resets the receiver and its flags |
| irq_en | input | 1 | Interrupt enable |
| stat_rd | input | 1 | One-cycle pulse marking a status read |
| data_rd | input | 1 | One-cycle pulse marking a data read |
| rx_data | output | DATA_W | Last accepted byte |
| full_flag | output | 1 | Data-full flag |
| ovr_flag | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: accepting a new byte, and the data read that finishes the clear of the flag. To provoke this, the bench first measures the latency from the start edge of a frame to the rise of full_flag. It then loads a byte, issues the status read, and times the data read for exactly the edge where the next frame's byte arrives. The outcome passes when rx_data holds the new byte, full_flag is still 1 and ovr_flag is 0. A data_rd issued afterwards must not clear the flag, because the status read was consumed.

// File: rtl/manch_pkg.sv
package manch_pkg;
  typedef enum logic {SL_IDLE, SL_RUN} slice_st_e;
endpackage

// File: rtl/manch_line_sync.sv
module manch_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prv;

  // the line idles high, so reset to 1 to avoid a false start edge
  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '1;
      prv <= 1'b1;
    end else begin
      sr <= {sr[STAGES-2:0], line_in};
      if (tick) prv <= sr[STAGES-1];
    end
  end

  assign level = sr[STAGES-1];
  assign rise  = tick &  level & ~prv;
  assign fall  = tick & ~level &  prv;
endmodule

// File: rtl/manch_bit_slicer.sv
module manch_bit_slicer
  import manch_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              level,
  input  logic              rise,
  input  logic              fall,
  output logic              byte_ok,
  output logic [DATA_W-1:0] byte_out
);
  localparam int PH_W  = $clog2(OVS);
  localparam int POS_W = $clog2(DATA_W + 2);
  localparam logic [PH_W-1:0]  PH_Q1   = PH_W'(OVS / 4);
  localparam logic [PH_W-1:0]  PH_Q3   = PH_W'((3 * OVS) / 4);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0]  PH_LO   = PH_W'(OVS / 2 - OVS / 8);
  localparam logic [PH_W-1:0]  PH_HI   = PH_W'(OVS / 2 + OVS / 8);
  localparam logic [PH_W-1:0]  PH_RSY  = PH_W'(OVS / 2 + 1);
  localparam logic [POS_W-1:0] POS_SYN = '0;
  localparam logic [POS_W-1:0] POS_END = POS_W'(DATA_W + 1);

  slice_st_e         st;
  logic [PH_W-1:0]   phase;
  logic [POS_W-1:0]  pos;
  logic              h1;
  logic [DATA_W-1:0] sh;
  logic              in_win;

  assign in_win = (phase >= PH_LO) && (phase <= PH_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SL_IDLE;
      phase    <= '0;
      pos      <= '0;
      h1       <= 1'b0;
      sh       <= '0;
      byte_ok  <= 1'b0;
      byte_out <= '0;
    end else begin
      byte_ok <= 1'b0;
      if (tick) begin
        case (st)
          SL_IDLE: begin
            if (fall) begin
              st    <= SL_RUN;
              phase <= PH_W'(1);
              pos   <= POS_SYN;
            end
          end
          default: begin
            if (phase == PH_LAST) begin
              phase <= '0;
              pos   <= pos + 1'b1;
            end else begin
              phase <= phase + 1'b1;
            end
            // mid-bit edge realigns the phase counter
            if ((rise || fall) && in_win && (pos != POS_END))
              phase <= PH_RSY;
            if (phase == PH_Q1) h1 <= level;
            if (phase == PH_Q3) begin
              if (pos == POS_END) begin
                byte_ok  <= (h1 == level);
                byte_out <= sh;
                st       <= SL_IDLE;
              end else if (h1 == level) begin
                st <= SL_IDLE;
              end else if (pos == POS_SYN) begin
                if (!level) st <= SL_IDLE;
              end else begin
                sh <= {sh[DATA_W-2:0], level};
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/manch_flag_regs.sv
module manch_flag_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_en,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              byte_ok,
  input  logic [DATA_W-1:0] byte_in,
  output logic [DATA_W-1:0] rx_data,
  output logic              full_flag,
  output logic              ovr_flag,
  output logic              irq
);
  logic armed;
  logic clr_now;

  assign clr_now = data_rd & armed;

  always_ff @(posedge clk) begin
    if (rst || !dec_en) begin
      rx_data   <= '0;
      full_flag <= 1'b0;
      ovr_flag  <= 1'b0;
      armed     <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= irq_en & (full_flag | ovr_flag);
      if (stat_rd && full_flag) armed <= 1'b1;
      if (clr_now) armed <= 1'b0;
      if (byte_ok) begin
        if (full_flag && !clr_now) begin
          ovr_flag <= 1'b1;
        end else begin
          rx_data   <= byte_in;
          full_flag <= 1'b1;
        end
      end else if (clr_now) begin
        full_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/manch_rx_flags.sv
module manch_rx_flags #(
  parameter int OVS        = 16,
  parameter int DATA_W     = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              line_in,
  input  logic              dec_en,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              full_flag,
  output logic              ovr_flag,
  output logic              irq
);
  logic              lvl, rise, fall;
  logic              rx_rst;
  logic              byte_ok;
  logic [DATA_W-1:0] byte_val;

  assign rx_rst = rst | ~dec_en;

  manch_line_sync #(.STAGES(SYNC_STAGE)) i_sync (
    .clk(clk), .rst(rst), .tick(os_tick), .line_in(line_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  manch_bit_slicer #(.OVS(OVS), .DATA_W(DATA_W)) i_slicer (
    .clk(clk), .rst(rx_rst), .tick(os_tick), .level(lvl),
    .rise(rise), .fall(fall), .byte_ok(byte_ok), .byte_out(byte_val)
  );

  manch_flag_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .dec_en(dec_en), .irq_en(irq_en),
    .stat_rd(stat_rd), .data_rd(data_rd), .byte_ok(byte_ok),
    .byte_in(byte_val), .rx_data(rx_data), .full_flag(full_flag),
    .ovr_flag(ovr_flag), .irq(irq)
  );
endmodule

// File: rtl/manch_rx_flags_chk.sv
module manch_rx_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dec_en,
  input logic              irq_en,
  input logic              data_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              full_flag,
  input logic              ovr_flag,
  input logic              irq
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!full_flag && !ovr_flag && !irq && rx_data == '0));

  assert_irq_raise_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_en && irq_en && (full_flag || ovr_flag)) |=> irq);

  assert_irq_mask_R5: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  assert_full_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(full_flag) |-> ($past(data_rd) || !$past(dec_en)));

  assert_ovr_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> $past(full_flag));

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (full_flag && $past(full_flag) && $past(dec_en) && !$past(data_rd))
      |-> $stable(rx_data));

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !dec_en |=> (!full_flag && !ovr_flag));
endmodule

bind manch_rx_flags manch_rx_flags_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .dec_en(dec_en), .irq_en(irq_en),
  .data_rd(data_rd), .rx_data(rx_data), .full_flag(full_flag),
  .ovr_flag(ovr_flag), .irq(irq)
);

// File: tb/test_manch_rx_flags.sv
`timescale 1ns/1ps
module test_manch_rx_flags;
  localparam int OVS  = 16;
  localparam int HALF = OVS / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic       line_in = 1'b1;
  logic       dec_en = 1'b1;
  logic       irq_en = 1'b0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       full_flag, ovr_flag, irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int frame_t0 = 0;
  int lat    = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  manch_rx_flags i_manch_rx_flags (
    .clk(clk), .rst(rst), .os_tick(os_tick), .line_in(line_in),
    .dec_en(dec_en), .irq_en(irq_en), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .full_flag(full_flag), .ovr_flag(ovr_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half_bit(input logic lv);
    line_in = lv;
    repeat (HALF) @(negedge clk);
  endtask

  // viol: index of data bit sent with no transition, -1 for none
  task automatic send_frame(input logic [7:0] b, input logic end_lvl,
                            input bit end_bad, input int viol);
    frame_t0 = cyc;
    half_bit(1'b0); half_bit(1'b1);
    for (int i = 7; i >= 0; i--) begin
      if (viol == i) begin half_bit(1'b1); half_bit(1'b1); end
      else begin half_bit(~b[i]); half_bit(b[i]); end
    end
    if (end_bad) begin half_bit(~end_lvl); half_bit(end_lvl); end
    else begin half_bit(end_lvl); half_bit(end_lvl); end
    line_in = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_data();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
  endtask

  task automatic do_clear();
    pulse_stat(); pulse_data();
  endtask

  task automatic t_reset();
    chk("R1 full", full_flag, 0);
    chk("R1 ovr", ovr_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 data", rx_data, 8'h00);
  endtask

  task automatic t_basic();
    fork
      send_frame(8'hA5, 1'b1, 0, -1);
      begin
        @(negedge clk);
        while (!full_flag) @(negedge clk);
        lat = cyc - frame_t0;
      end
    join
    chk("R2 data A5", rx_data, 8'hA5);
    chk("R2 full", full_flag, 1);
    chk("R5 irq masked", irq, 0);
    pulse_data();
    chk("R6 data_rd alone keeps full", full_flag, 1);
    do_clear();
    chk("R6 status+data clears full", full_flag, 0);
  endtask

  task automatic t_patterns();
    send_frame(8'h3C, 1'b0, 0, -1);
    chk("R10 low close data", rx_data, 8'h3C);
    chk("R10 low close full", full_flag, 1);
    do_clear();
    send_frame(8'h00, 1'b1, 0, -1);
    chk("R2 data 00", rx_data, 8'h00);
    chk("R2 full 00", full_flag, 1);
    do_clear();
    send_frame(8'hFF, 1'b0, 0, -1);
    chk("R2 data FF", rx_data, 8'hFF);
    do_clear();
  endtask

  task automatic t_bad_close();
    send_frame(8'h77, 1'b1, 1, -1);
    chk("R3 full stays 0", full_flag, 0);
    chk("R3 data kept", rx_data, 8'hFF);
    chk("R3 ovr stays 0", ovr_flag, 0);
  endtask

  task automatic t_violation();
    send_frame(8'h96, 1'b1, 0, 3);
    chk("R4 full stays 0", full_flag, 0);
    chk("R4 data kept", rx_data, 8'hFF);
  endtask

  task automatic t_irq_ovr();
    irq_en = 1'b1;
    send_frame(8'h5A, 1'b1, 0, -1);
    chk("R5 irq on full", irq, 1);
    send_frame(8'h81, 1'b1, 0, -1);
    chk("R7 ovr set", ovr_flag, 1);
    chk("R7 old byte kept", rx_data, 8'h5A);
    chk("R7 full still set", full_flag, 1);
    chk("R5 irq on ovr", irq, 1);
    irq_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 irq masked", irq, 0);
  endtask

  task automatic t_disable();
    dec_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 full cleared", full_flag, 0);
    chk("R8 ovr cleared", ovr_flag, 0);
    chk("R8 data cleared", rx_data, 8'h00);
    send_frame(8'h42, 1'b1, 0, -1);
    dec_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 frame ignored", full_flag, 0);
  endtask

  task automatic t_collision();
    send_frame(8'h11, 1'b1, 0, -1);
    chk("R9 first byte", rx_data, 8'h11);
    pulse_stat();
    fork
      send_frame(8'hE7, 1'b0, 0, -1);
      begin
        do @(negedge clk); while (cyc != frame_t0 + lat - 1);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
      end
    join
    chk("R9 new byte loaded", rx_data, 8'hE7);
    chk("R9 full stays", full_flag, 1);
    chk("R9 no overrun", ovr_flag, 0);
    pulse_data();
    chk("R9 status read consumed", full_flag, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_patterns();
    t_bad_close();
    t_violation();
    t_irq_ovr();
    t_disable();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule